// File: doc/BRIEF.md
# Strobed Serial Command Port for a Multiplexed Segment Display

This block receives bytes from a host over a three-wire link: an active-low strobe that frames a transfer, a shift clock, and a serial data line. Inside each strobe-low window the first complete byte is decoded as a command. Every later complete byte is display data that goes to the display memory. Four command kinds set the display mode, the data-transfer setting, the status flags, or the memory group address directly.

The block holds the configuration registers and the group-address pointer. The pointer advances by itself after each data byte and wraps to zero past a limit set by the selected multiplex ratio. Its outputs are a registered RAM write port, the decoded configuration flags, and one-cycle pulses that mark each strobe edge. Downstream logic uses these pulses to time output latching and display-enable changes. The RAM array, the output latches and the drive-waveform generation sit outside this block.

The link inputs are taken as synchronous to `clk`. The host holds each shift-clock level for at least one clock period.

Top module: `lcd_cmd_port`

## Requirements
- R1: `ser_sdi` is sampled at the first `clk` edge that sees a rising `ser_sck` while `ser_stb` is low. Bits shift in most significant first. Shift-clock activity while `ser_stb` is high has no effect on any output.
- R2: The first complete byte after `ser_stb` falls is a command. Every further complete byte in the same low window is a data byte.
- R3: Command bits [7:6] select the kind: 00 display mode, 01 data setting, 10 status, 11 address. Only the addressed register group changes.
- R4: A display-mode command loads `duty_code` from bits [1:0] and `frame_div` from bits [3:2]. The `duty_code` values 00 and 01 mean 2-way multiplex with group limit 14, 10 means 3-way with limit 19, and 11 means 4-way with limit 29.
- R5: A data-setting command loads `latch_on_data` from bit 3, `addr_hold` from bit 2 and `wr_mode` from bits [1:0]. When `wr_mode[1]` is 1, data bytes cause no RAM write and leave the pointer unchanged.
- R6: A status command loads `test_sel` from bits [5:4], `int_bias` from bit 3, `clr_addr_en` from bit 2, `latch_every` from bit 1 and `disp_on` from bit 0.
- R7: An address command loads the pointer from bits [4:0]. A data byte is written to the pointer value reduced modulo (limit+1), so `ram_addr` never exceeds the current limit.
- R8: Each accepted data byte pulses `ram_we` for one cycle, two clock edges after the edge that samples its last bit. When `addr_hold` is 0 the pointer then moves to the written address plus one, or to 0 if the written address equals the limit. When `addr_hold` is 1 the pointer stays where it is.
- R9: When `clr_addr_en` is 1, the pointer clears to 0 on the strobe rising edge that closes a window in which at least one data byte was written.
- R10: A byte left incomplete when `ser_stb` rises is discarded. The next window starts with a fresh command byte.
- R11: `stb_fall_evt` and `stb_rise_evt` each pulse for exactly one cycle, one edge after the edge that first sees `ser_stb` low or high.
- R12: After reset all configuration outputs, `ram_we` and both event outputs are 0, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_stb | input | 1 | Active-low transfer strobe |
| ser_sck | input | 1 | Shift clock, rising edge samples data |
| ser_sdi | input | 1 | Serial data, MSB first |
| ram_we | output | 1 | Display RAM write pulse |
| ram_addr | output | 5 | Group address of the write |
| ram_wdata | output | 8 | Data byte of the write |
| duty_code | output | 2 | Multiplex/bias selection |
| frame_div | output | 2 | Frame-rate divider selection |
| latch_on_data | output | 1 | Latch after data on next strobe rise |
| addr_hold | output | 1 | 1 holds the pointer, 0 auto-increments |
| wr_mode | output | 2 | Write mode, 1x is prohibited |
| test_sel | output | 2 | Master/slave/test selection |
| int_bias | output | 1 | Internal bias generator selected |
| clr_addr_en | output | 1 | Clear pointer after a data window |
| latch_every | output | 1 | Latch on every strobe rise |
| disp_on | output | 1 | Display enable flag |
| stb_rise_evt | output | 1 | One-cycle pulse after strobe rises |
| stb_fall_evt | output | 1 | One-cycle pulse after strobe falls |

## Verification
Assertions check on every cycle that no byte completes while the strobe is high, and that a written address never exceeds the limit for the current multiplex ratio. They also check that the pointer after a write is the increment or the wrap of the written address, that prohibited write modes never write, and that each register group changes only on its own command. Other behaviours show only through the bench's framed transfers: command-versus-data ordering inside a window, the modulo fold after an out-of-range address command, hold mode, and the pointer clear on the closing strobe edge. The same holds for dropping partial bytes and ignoring shift clocks while idle. The bench compares each window's captured writes and register state against a model built from the requirements.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = 5;
    localparam int LIM_2WAY    = 14;
    localparam int LIM_3WAY    = 19;
    localparam int LIM_4WAY    = 29;
    localparam int FOLD_STEPS  = 2;

    typedef enum logic [1:0] {
        OP_MODE = 2'b00,
        OP_DSET = 2'b01,
        OP_STAT = 2'b10,
        OP_ADDR = 2'b11
    } op_e;

    typedef struct packed {
        logic [1:0] duty;
        logic [1:0] frame_div;
    } mode_cfg_t;

    typedef struct packed {
        logic       latch_on_data;
        logic       hold_addr;
        logic [1:0] wr_mode;
    } dset_cfg_t;

    typedef struct packed {
        logic [1:0] test_sel;
        logic       int_bias;
        logic       clr_addr;
        logic       latch_every;
        logic       disp_on;
    } stat_cfg_t;

    function automatic logic [ADDR_W-1:0] duty_limit(input logic [1:0] duty);
        case (duty)
            2'b10:   return ADDR_W'(LIM_3WAY);
            2'b11:   return ADDR_W'(LIM_4WAY);
            default: return ADDR_W'(LIM_2WAY);
        endcase
    endfunction

    // Reduce an address into 0..lim by repeated subtraction of (lim+1).
    function automatic logic [ADDR_W-1:0] fold_addr(input logic [ADDR_W-1:0] a,
                                                    input logic [ADDR_W-1:0] lim);
        logic [ADDR_W:0] r;
        logic [ADDR_W:0] span;
        r    = {1'b0, a};
        span = {1'b0, lim} + 1'b1;
        for (int i = 0; i < FOLD_STEPS; i++) begin
            if (r > {1'b0, lim}) r = r - span;
        end
        return r[ADDR_W-1:0];
    endfunction

endpackage

// File: rtl/lcd_link_rx.sv
module lcd_link_rx
    import lcd_cmd_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_stb,
    input  logic         ser_sck,
    input  logic         ser_sdi,
    output logic         byte_vld,
    output logic         byte_is_cmd,
    output logic [W-1:0] byte_data,
    output logic         stb_rise,
    output logic         stb_fall
);
    localparam int CNT_W = $clog2(W);

    logic             stb_q;
    logic             sck_q;
    logic [CNT_W-1:0] bit_cnt;
    logic [W-1:0]     shreg;
    logic             first_pend;
    logic             fall_c;
    logic             rise_c;
    logic             sck_up_c;

    assign fall_c   = stb_q & ~ser_stb;
    assign rise_c   = ~stb_q & ser_stb;
    assign sck_up_c = ser_sck & ~sck_q & ~ser_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q       <= 1'b1;
            sck_q       <= 1'b0;
            bit_cnt     <= '0;
            shreg       <= '0;
            first_pend  <= 1'b0;
            byte_vld    <= 1'b0;
            byte_is_cmd <= 1'b0;
            byte_data   <= '0;
            stb_rise    <= 1'b0;
            stb_fall    <= 1'b0;
        end else begin
            stb_q    <= ser_stb;
            sck_q    <= ser_sck;
            stb_rise <= rise_c;
            stb_fall <= fall_c;
            byte_vld <= 1'b0;
            if (ser_stb) begin
                bit_cnt <= '0;
            end else if (fall_c) begin
                bit_cnt    <= '0;
                first_pend <= 1'b1;
            end else if (sck_up_c) begin
                shreg <= {shreg[W-2:0], ser_sdi};
                if (bit_cnt == CNT_W'(W - 1)) begin
                    bit_cnt     <= '0;
                    byte_vld    <= 1'b1;
                    byte_data   <= {shreg[W-2:0], ser_sdi};
                    byte_is_cmd <= first_pend;
                    first_pend  <= 1'b0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R1: no byte completes from an edge at which the strobe is high
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        ser_stb |=> !byte_vld);

    // R11: edge pulses last a single cycle
    p_rise_single_r11: assert property (@(posedge clk) disable iff (rst)
        stb_rise |=> !stb_rise);
    p_fall_single_r11: assert property (@(posedge clk) disable iff (rst)
        stb_fall |=> !stb_fall);

endmodule

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
    import lcd_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic              byte_is_cmd,
    input  logic [BYTE_W-1:0] byte_data,
    output mode_cfg_t         mode_q,
    output dset_cfg_t         dset_q,
    output stat_cfg_t         stat_q,
    output logic              addr_load,
    output logic [ADDR_W-1:0] addr_val
);
    logic cmd_c;
    op_e  op_c;

    assign cmd_c     = byte_vld & byte_is_cmd;
    assign op_c      = op_e'(byte_data[7:6]);
    assign addr_load = cmd_c && (op_c == OP_ADDR);
    assign addr_val  = byte_data[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            dset_q <= '0;
            stat_q <= '0;
        end else if (cmd_c) begin
            case (op_c)
                OP_MODE: begin
                    mode_q.duty      <= byte_data[1:0];
                    mode_q.frame_div <= byte_data[3:2];
                end
                OP_DSET: begin
                    dset_q.latch_on_data <= byte_data[3];
                    dset_q.hold_addr     <= byte_data[2];
                    dset_q.wr_mode       <= byte_data[1:0];
                end
                OP_STAT: begin
                    stat_q.test_sel    <= byte_data[5:4];
                    stat_q.int_bias    <= byte_data[3];
                    stat_q.clr_addr    <= byte_data[2];
                    stat_q.latch_every <= byte_data[1];
                    stat_q.disp_on     <= byte_data[0];
                end
                default: ;
            endcase
        end
    end

    // R3: each register group moves only on its own command kind
    p_mode_only_r3: assert property (@(posedge clk) disable iff (rst)
        !(cmd_c && byte_data[7:6] == 2'b00) |=> $stable(mode_q));
    p_dset_only_r3: assert property (@(posedge clk) disable iff (rst)
        !(cmd_c && byte_data[7:6] == 2'b01) |=> $stable(dset_q));
    p_stat_only_r3: assert property (@(posedge clk) disable iff (rst)
        !(cmd_c && byte_data[7:6] == 2'b10) |=> $stable(stat_q));

    // R6: display enable follows bit 0 of a status command
    p_disp_load_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_c && byte_data[7:6] == 2'b10) |=> (stat_q.disp_on == $past(byte_data[0])));

endmodule

// File: rtl/lcd_addr_ptr.sv
module lcd_addr_ptr
    import lcd_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              data_vld,
    input  logic              wr_ok,
    input  logic              hold,
    input  logic [1:0]        duty,
    input  logic              clr_en,
    input  logic              stb_rise,
    output logic              do_write,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] ptr_q
);
    logic [ADDR_W-1:0] lim_c;
    logic              wrote_q;

    assign lim_c    = duty_limit(duty);
    assign eff_addr = fold_addr(ptr_q, lim_c);
    assign do_write = data_vld & wr_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            wrote_q <= 1'b0;
        end else if (stb_rise) begin
            if (clr_en && wrote_q) ptr_q <= '0;
            wrote_q <= 1'b0;
        end else if (addr_load) begin
            ptr_q <= addr_val;
        end else if (do_write) begin
            wrote_q <= 1'b1;
            if (!hold) ptr_q <= (eff_addr == lim_c) ? '0 : eff_addr + 1'b1;
        end
    end

    // R9: a closing strobe edge after a write clears the pointer when enabled
    p_clr_after_write_r9: assert property (@(posedge clk) disable iff (rst)
        (stb_rise && clr_en && wrote_q) |=> (ptr_q == '0));

    // R8: hold mode leaves the pointer where it was
    p_hold_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (do_write && hold && !addr_load && !stb_rise) |=> $stable(ptr_q));

endmodule

// File: rtl/lcd_cmd_port.sv
module lcd_cmd_port
    import lcd_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_stb,
    input  logic              ser_sck,
    input  logic              ser_sdi,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [BYTE_W-1:0] ram_wdata,
    output logic [1:0]        duty_code,
    output logic [1:0]        frame_div,
    output logic              latch_on_data,
    output logic              addr_hold,
    output logic [1:0]        wr_mode,
    output logic [1:0]        test_sel,
    output logic              int_bias,
    output logic              clr_addr_en,
    output logic              latch_every,
    output logic              disp_on,
    output logic              stb_rise_evt,
    output logic              stb_fall_evt
);
    logic              byte_vld;
    logic              byte_is_cmd;
    logic [BYTE_W-1:0] byte_data;
    mode_cfg_t         mode_q;
    dset_cfg_t         dset_q;
    stat_cfg_t         stat_q;
    logic              addr_load;
    logic [ADDR_W-1:0] addr_val;
    logic              do_write;
    logic [ADDR_W-1:0] eff_addr;
    logic [ADDR_W-1:0] ptr_now;

    lcd_link_rx #(.W(BYTE_W)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .ser_stb     (ser_stb),
        .ser_sck     (ser_sck),
        .ser_sdi     (ser_sdi),
        .byte_vld    (byte_vld),
        .byte_is_cmd (byte_is_cmd),
        .byte_data   (byte_data),
        .stb_rise    (stb_rise_evt),
        .stb_fall    (stb_fall_evt)
    );

    lcd_cfg_regs u_cfg (
        .clk         (clk),
        .rst         (rst),
        .byte_vld    (byte_vld),
        .byte_is_cmd (byte_is_cmd),
        .byte_data   (byte_data),
        .mode_q      (mode_q),
        .dset_q      (dset_q),
        .stat_q      (stat_q),
        .addr_load   (addr_load),
        .addr_val    (addr_val)
    );

    lcd_addr_ptr u_ptr (
        .clk       (clk),
        .rst       (rst),
        .addr_load (addr_load),
        .addr_val  (addr_val),
        .data_vld  (byte_vld & ~byte_is_cmd),
        .wr_ok     (~dset_q.wr_mode[1]),
        .hold      (dset_q.hold_addr),
        .duty      (mode_q.duty),
        .clr_en    (stat_q.clr_addr),
        .stb_rise  (stb_rise_evt),
        .do_write  (do_write),
        .eff_addr  (eff_addr),
        .ptr_q     (ptr_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we <= do_write;
            if (do_write) begin
                ram_addr  <= eff_addr;
                ram_wdata <= byte_data;
            end
        end
    end

    assign duty_code     = mode_q.duty;
    assign frame_div     = mode_q.frame_div;
    assign latch_on_data = dset_q.latch_on_data;
    assign addr_hold     = dset_q.hold_addr;
    assign wr_mode       = dset_q.wr_mode;
    assign test_sel      = stat_q.test_sel;
    assign int_bias      = stat_q.int_bias;
    assign clr_addr_en   = stat_q.clr_addr;
    assign latch_every   = stat_q.latch_every;
    assign disp_on       = stat_q.disp_on;

    // R7: written addresses stay inside the current limit
    p_addr_in_range_r7: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_addr <= duty_limit(duty_code)));

    // R8: after a write in increment mode the pointer is the next address or wraps
    p_autoinc_r8: assert property (@(posedge clk) disable iff (rst)
        (ram_we && !addr_hold) |->
            (ptr_now == ((ram_addr == duty_limit(duty_code)) ? '0 : ram_addr + 1'b1)));

    // R5: prohibited write modes never produce a write
    p_no_prohibited_write_r5: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> !wr_mode[1]);

    // R11: the two edge pulses never coincide
    p_edges_apart_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stb_rise_evt, stb_fall_evt}));

endmodule

// File: tb/test_lcd_cmd_port.sv
`timescale 1ns/1ps
module test_lcd_cmd_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_stb = 1'b1;
    logic       ser_sck = 1'b0;
    logic       ser_sdi = 1'b0;
    logic       ram_we;
    logic [4:0] ram_addr;
    logic [7:0] ram_wdata;
    logic [1:0] duty_code, frame_div, wr_mode, test_sel;
    logic       latch_on_data, addr_hold, int_bias, clr_addr_en, latch_every, disp_on;
    logic       stb_rise_evt, stb_fall_evt;

    always #2.5 clk = ~clk;

    lcd_cmd_port i_lcd_cmd_port (
        .clk(clk), .rst(rst), .ser_stb(ser_stb), .ser_sck(ser_sck), .ser_sdi(ser_sdi),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .duty_code(duty_code), .frame_div(frame_div), .latch_on_data(latch_on_data),
        .addr_hold(addr_hold), .wr_mode(wr_mode), .test_sel(test_sel), .int_bias(int_bias),
        .clr_addr_en(clr_addr_en), .latch_every(latch_every), .disp_on(disp_on),
        .stb_rise_evt(stb_rise_evt), .stb_fall_evt(stb_fall_evt)
    );

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    // write capture and edge counts
    logic [4:0] cap_addr [2048];
    logic [7:0] cap_data [2048];
    int cap_n = 0;
    int rise_n = 0;
    int fall_n = 0;
    int win_n = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (ram_we && cap_n < 2048) begin
                cap_addr[cap_n] = ram_addr;
                cap_data[cap_n] = ram_wdata;
                cap_n++;
            end
            if (stb_rise_evt) rise_n++;
            if (stb_fall_evt) fall_n++;
        end
    end

    // model state
    logic [1:0] m_duty = 0, m_fdiv = 0, m_wm = 0, m_test = 0;
    logic       m_lod = 0, m_hold = 0, m_bias = 0, m_clr = 0, m_lev = 0, m_on = 0;
    int         m_ptr = 0;
    bit         m_wrote = 0;
    logic [4:0] exp_addr [2048];
    logic [7:0] exp_data [2048];
    int exp_n = 0;

    logic [7:0] wd [8];

    function automatic int lim_of(input logic [1:0] d);
        if (d == 2'b11) return 29;
        if (d == 2'b10) return 19;
        return 14;
    endfunction

    function automatic logic [15:0] exp_cfg();
        return {m_duty, m_fdiv, m_lod, m_hold, m_wm, m_test, m_bias, m_clr, m_lev, m_on};
    endfunction

    function automatic logic [15:0] act_cfg();
        return {duty_code, frame_div, latch_on_data, addr_hold, wr_mode, test_sel,
                int_bias, clr_addr_en, latch_every, disp_on};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [7:0] b, input int nb);
        for (int i = 0; i < nb; i++) begin
            ser_sdi = b[7-i];
            ser_sck = 1'b0;
            tick(2);
            ser_sck = 1'b1;
            tick(2);
        end
        ser_sck = 1'b0;
    endtask

    // model update for one window (R2..R9)
    task automatic model_window(input bit has_cmd, input logic [7:0] cmd, input int nd);
        int lim;
        int eff;
        if (has_cmd) begin
            case (cmd[7:6])
                2'b00: begin m_duty = cmd[1:0]; m_fdiv = cmd[3:2]; end
                2'b01: begin m_lod = cmd[3]; m_hold = cmd[2]; m_wm = cmd[1:0]; end
                2'b10: begin m_test = cmd[5:4]; m_bias = cmd[3]; m_clr = cmd[2];
                             m_lev = cmd[1]; m_on = cmd[0]; end
                default: m_ptr = cmd[4:0];
            endcase
            for (int k = 0; k < nd; k++) begin
                if (!m_wm[1]) begin
                    lim = lim_of(m_duty);
                    eff = m_ptr;
                    while (eff > lim) eff = eff - (lim + 1);
                    exp_addr[exp_n] = 5'(eff);
                    exp_data[exp_n] = wd[k];
                    exp_n++;
                    m_wrote = 1;
                    if (!m_hold) m_ptr = (eff == lim) ? 0 : eff + 1;
                end
            end
        end
        if (m_clr && m_wrote) m_ptr = 0;
        m_wrote = 0;
    endtask

    // one strobe-low window: optional command, nd data bytes, npart trailing bits
    task automatic run_window(input bit has_cmd, input logic [7:0] cmd, input int nd,
                              input int npart, input string tag);
        int base;
        base = cap_n;
        for (int k = 0; k < nd; k++) wd[k] = 8'($urandom);
        ser_stb = 1'b0;
        tick(2);
        if (has_cmd) begin
            shift_bits(cmd, 8);
            for (int k = 0; k < nd; k++) shift_bits(wd[k], 8);
        end
        if (npart > 0) shift_bits(8'($urandom), npart);
        tick(2);
        ser_stb = 1'b1;
        tick(4);
        win_n++;
        begin
            int exp_base;
            exp_base = exp_n;
            model_window(has_cmd, cmd, has_cmd ? nd : 0);
            check(cap_n - base == exp_n - exp_base, {tag, " R8 write count"},
                  cap_n - base, exp_n - exp_base);
            for (int k = 0; k < exp_n - exp_base && base + k < cap_n; k++) begin
                check(cap_addr[base+k] == exp_addr[exp_base+k], {tag, " R7 write address"},
                      cap_addr[base+k], exp_addr[exp_base+k]);
                check(cap_data[base+k] == exp_data[exp_base+k], {tag, " R1 write data"},
                      cap_data[base+k], exp_data[exp_base+k]);
            end
        end
        check(act_cfg() == exp_cfg(), {tag, " R3 register state"}, act_cfg(), exp_cfg());
        check(rise_n == win_n && fall_n == win_n, {tag, " R11 edge pulses"},
              rise_n * 1000 + fall_n, win_n * 1000 + win_n);
    endtask

    task automatic idle_clocks_high(input int nb);
        int base;
        base = cap_n;
        shift_bits(8'($urandom), nb);
        tick(3);
        check(cap_n == base, "R1 idle shift write", cap_n - base, 0);
        check(act_cfg() == exp_cfg(), "R1 idle shift state", act_cfg(), exp_cfg());
        check(rise_n == win_n && fall_n == win_n, "R1 idle shift edges",
              rise_n + fall_n, 2 * win_n);
    endtask

    initial begin
        void'($urandom(32'd24601));
        tick(4);
        rst = 1'b0;
        tick(2);
        // R12 reset state
        check(act_cfg() == 16'h0, "R12 reset registers", act_cfg(), 0);
        check(!ram_we && !stb_rise_evt && !stb_fall_evt, "R12 reset pulses",
              {ram_we, stb_rise_evt, stb_fall_evt}, 0);

        // R12 pointer starts at 0; R2 command then data
        run_window(1, 8'h40, 2, 0, "R12 ptr");
        // R4 2-way limit wrap, R8 wrap
        run_window(1, 8'h01, 0, 0, "R4 duty 2way");
        run_window(1, 8'hC0 | 8'd13, 3, 0, "R8 wrap 14");
        // R4 4-way
        run_window(1, 8'h0F, 0, 0, "R4 duty 4way");
        run_window(1, 8'hC0 | 8'd28, 3, 0, "R8 wrap 29");
        // R7 out-of-range address under 3-way
        run_window(1, 8'h06, 0, 0, "R4 duty 3way");
        run_window(1, 8'hC0 | 8'd31, 2, 0, "R7 fold");
        // R8 hold mode
        run_window(1, 8'h44, 0, 0, "R5 hold set");
        run_window(1, 8'hC5, 3, 0, "R8 hold");
        // R5 prohibited mode
        run_window(1, 8'h42, 2, 0, "R5 prohibited");
        run_window(1, 8'h43, 2, 0, "R5 prohibited 11");
        // R9 address clear
        run_window(1, 8'h40, 0, 0, "R5 auto set");
        run_window(1, 8'h84, 0, 0, "R6 status clr");
        run_window(1, 8'hC7, 2, 0, "R9 write then clr");
        run_window(1, 8'h40, 1, 0, "R9 after clr");
        // R6 all status bits
        run_window(1, 8'hBF, 0, 0, "R6 status all");
        // R1 shift clocks while idle
        idle_clocks_high(8);
        // R10 partial bytes
        run_window(1, 8'h00, 0, 5, "R10 partial after cmd");
        run_window(0, 8'h00, 0, 3, "R10 partial only");
        run_window(1, 8'h0B, 0, 0, "R10 fresh cmd");
        run_window(1, 8'h40, 1, 7, "R10 partial data");

        // constrained random windows
        for (int w = 0; w < 240; w++) begin
            logic [7:0] c;
            int nd, np;
            c = 8'($urandom);
            if (c[7:6] == 2'b01 && ($urandom % 4) != 0) c[1] = 1'b0;
            nd = $urandom % 5;
            np = (($urandom % 3) == 0) ? 1 + ($urandom % 7) : 0;
            if (($urandom % 10) == 0) idle_clocks_high(1 + ($urandom % 8));
            run_window(($urandom % 12) != 0, c, nd, np, "R2 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule